// File: doc/BRIEF.md
# Audio Replay DMA Address Engine

This block streams audio samples out of memory for a frame-based replay path. Software programs a 24-bit start address and a 24-bit end address one byte at a time, chooses a sample format and a rate in a mode register, and starts replay through a control register. On every rate tick the engine reads the bytes that make up one output frame (one sample in mono, a left and a right sample in stereo) from a simple byte-wide memory read port. It then presents a left/right pair on the sample outputs with a one-cycle strobe.

When the fetch pointer reaches the end address, the engine signals end of frame. In repeat mode it then reloads both working addresses from the programmed registers and continues. Otherwise it clears its run bit and halts. The start and end registers are copied into working registers only when replay starts and at each wrap, so software can prepare the next buffer while the current one plays. The end-of-frame event can be routed to an interrupt line, to a timer event output, or to both. The live fetch pointer can be read back as three bytes.

Top module: `replay_dma`

## Requirements
- R1: After reset every readable register reads 0. Register offsets are: 0 control, 1 mode, 2 event routing, 4/5/6 start high/middle/low, 8/9/10 end high/middle/low, 12/13/14 current pointer high/middle/low. Start, end, mode (bits 7, 6, 1:0) and routing (bits 0, 2) read back what was written, with unused bits reading 0.
- R2: The current pointer reads as three bytes whose combination high<<16 + middle<<8 + low equals the address of the next byte to be fetched. After a non-repeat frame ends, it equals the end address.
- R3: Writing control with bit 0 set while stopped loads the pointer from the start register. Each byte fetched through the memory port advances the pointer by one, so an 8-bit sample advances it by 1 and a 16-bit sample by 2.
- R4: Mode bit 6 set selects 16-bit samples (high byte at the lower address); clear selects 8-bit samples, which appear in the upper byte of the 16-bit output with a zero lower byte. Mode bit 7 set selects mono: one sample per tick, driven on both outputs. Clear selects stereo: left then right per tick.
- R5: Mode bits 1:0 set the tick period to DIV_BASE << (3 - rate) clock cycles, so consecutive sample strobes are exactly that far apart.
- R6: Rate code 0 mutes the outputs: strobes still occur and the pointer still advances, but both samples are 0.
- R7: When the pointer is at or beyond the working end address after a tick's fetch, frame_end pulses together with that tick's sample strobe. Without repeat (control bit 1 clear), control bit 0 then reads 0 and no further strobes occur.
- R8: With repeat set, the pointer reloads from the start register at frame end and replay continues. Start and end registers written during a frame take effect only at the next wrap.
- R9: Writing control with bit 0 clear stops replay: no further memory requests or sample strobes occur.
- R10: irq_line pulses with frame_end when routing bit 0 is set; timer_evt pulses with frame_end when routing bit 2 is set.
- R11: A memory request holds its address until acknowledged, and is only raised while replay runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write offset |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 4 | Register read offset |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read data |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| frame_end | output | 1 | End-of-frame pulse |
| irq_line | output | 1 | Routed end-of-frame interrupt |
| timer_evt | output | 1 | Routed end-of-frame timer event |

## Verification
The assertions check on every cycle that memory requests appear only while running and hold their address until acknowledged. They also check that sample strobes are single-cycle, that frame_end coincides with a strobe, and that both routed outputs imply frame_end. Only the bench scenarios can show the data side. That covers the exact sample values for each format against a known memory pattern, strobe spacing at every rate, muting, the pointer value read back after a frame, deferred start/end updates across a repeat wrap, and silence after a stop.

// File: rtl/replay_dma.sv
module replay_dma #(
  parameter int DIV_BASE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic [3:0]  reg_raddr,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        smp_valid,
  output logic [15:0] smp_left,
  output logic [15:0] smp_right,
  output logic        frame_end,
  output logic        irq_line,
  output logic        timer_evt
);
  localparam int CW = $clog2(DIV_BASE * 8) + 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_t;
  state_t state;

  logic        ctrl_on, ctrl_rep;
  logic        md_mono, md_b16;
  logic [1:0]  md_rate;
  logic        rt_irq, rt_tmr;
  logic [23:0] st_r, en_r, end_w, cur;
  logic [CW-1:0] cnt, period;
  logic        tick;
  logic [1:0]  bidx, nb;
  logic        f_mono, f_b16, f_mute;
  logic [7:0]  bytes [4];
  logic [15:0] l_nx, r_nx;

  assign period   = CW'(DIV_BASE) << (2'd3 - md_rate);
  assign tick     = ctrl_on && (cnt >= period - CW'(1));
  assign mem_req  = (state == S_FETCH);
  assign mem_addr = cur;

  always_comb begin
    if (f_b16) begin
      l_nx = {bytes[0], bytes[1]};
      r_nx = f_mono ? l_nx : {bytes[2], bytes[3]};
    end else begin
      l_nx = {bytes[0], 8'h00};
      r_nx = f_mono ? l_nx : {bytes[1], 8'h00};
    end
    if (f_mute) begin
      l_nx = '0;
      r_nx = '0;
    end
  end

  always_comb begin
    case (reg_raddr)
      4'd0:    reg_rdata = {6'b0, ctrl_rep, ctrl_on};
      4'd1:    reg_rdata = {md_mono, md_b16, 4'b0, md_rate};
      4'd2:    reg_rdata = {5'b0, rt_tmr, 1'b0, rt_irq};
      4'd4:    reg_rdata = st_r[23:16];
      4'd5:    reg_rdata = st_r[15:8];
      4'd6:    reg_rdata = st_r[7:0];
      4'd8:    reg_rdata = en_r[23:16];
      4'd9:    reg_rdata = en_r[15:8];
      4'd10:   reg_rdata = en_r[7:0];
      4'd12:   reg_rdata = cur[23:16];
      4'd13:   reg_rdata = cur[15:8];
      4'd14:   reg_rdata = cur[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctrl_on <= 1'b0; ctrl_rep <= 1'b0;
      md_mono <= 1'b0; md_b16 <= 1'b0; md_rate <= 2'd0;
      rt_irq <= 1'b0; rt_tmr <= 1'b0;
      st_r <= '0; en_r <= '0; end_w <= '0; cur <= '0;
      cnt <= '0; bidx <= '0; nb <= '0;
      f_mono <= 1'b0; f_b16 <= 1'b0; f_mute <= 1'b0;
      for (int i = 0; i < 4; i++) bytes[i] <= '0;
      smp_valid <= 1'b0; smp_left <= '0; smp_right <= '0;
      frame_end <= 1'b0; irq_line <= 1'b0; timer_evt <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      frame_end <= 1'b0;
      irq_line  <= 1'b0;
      timer_evt <= 1'b0;
      if (ctrl_on) cnt <= tick ? '0 : cnt + CW'(1);

      case (state)
        S_IDLE: if (tick) begin
          state  <= S_FETCH;
          bidx   <= 2'd0;
          nb     <= {md_b16 & ~md_mono, md_b16 | ~md_mono};
          f_mono <= md_mono;
          f_b16  <= md_b16;
          f_mute <= (md_rate == 2'd0);
        end
        S_FETCH: if (mem_ack) begin
          bytes[bidx] <= mem_rdata;
          cur  <= cur + 24'd1;
          bidx <= bidx + 2'd1;
          if (bidx == nb) state <= S_DONE;
        end
        S_DONE: begin
          state     <= S_IDLE;
          smp_valid <= 1'b1;
          smp_left  <= l_nx;
          smp_right <= r_nx;
          if (cur >= end_w) begin
            frame_end <= 1'b1;
            irq_line  <= rt_irq;
            timer_evt <= rt_tmr;
            if (ctrl_rep) begin
              cur   <= st_r;
              end_w <= en_r;
            end else begin
              ctrl_on <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase

      if (reg_wr) begin
        case (reg_addr)
          4'd0: begin
            ctrl_on  <= reg_wdata[0];
            ctrl_rep <= reg_wdata[1];
            if (reg_wdata[0] && !ctrl_on) begin
              cur   <= st_r;
              end_w <= en_r;
              cnt   <= '0;
              state <= S_IDLE;
            end
            if (!reg_wdata[0]) state <= S_IDLE;
          end
          4'd1: begin
            md_mono <= reg_wdata[7];
            md_b16  <= reg_wdata[6];
            md_rate <= reg_wdata[1:0];
          end
          4'd2: begin
            rt_irq <= reg_wdata[0];
            rt_tmr <= reg_wdata[2];
          end
          4'd4:  st_r[23:16] <= reg_wdata;
          4'd5:  st_r[15:8]  <= reg_wdata;
          4'd6:  st_r[7:0]   <= reg_wdata;
          4'd8:  en_r[23:16] <= reg_wdata;
          4'd9:  en_r[15:8]  <= reg_wdata;
          4'd10: en_r[7:0]   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/replay_dma_chk.sv
module replay_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_on,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [23:0] mem_addr,
  input logic        smp_valid,
  input logic        frame_end,
  input logic        irq_line,
  input logic        timer_evt
);
  assert_req_running_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ctrl_on);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_end_with_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> smp_valid);

  assert_irq_routed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line |-> frame_end);

  assert_timer_routed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timer_evt |-> frame_end);
endmodule

bind replay_dma replay_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_on(ctrl_on), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .smp_valid(smp_valid),
  .frame_end(frame_end), .irq_line(irq_line), .timer_evt(timer_evt)
);

// File: tb/test_replay_dma.sv
module test_replay_dma;
  localparam int DIVB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic smp_valid, frame_end, irq_line, timer_evt;
  logic [15:0] smp_left, smp_right;

  always #2 clk = ~clk;

  replay_dma #(.DIV_BASE(DIVB)) i_replay_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .frame_end(frame_end), .irq_line(irq_line),
    .timer_evt(timer_evt));

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= pat(mem_addr);
  end

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected-model state
  bit exp_active = 0, exp_rep = 0, exp_mono = 0, exp_b16 = 0, have_prev = 0;
  bit cfg_irq = 0, cfg_tmr = 0;
  logic [1:0] exp_rate = 0;
  logic [23:0] exp_ptr = 0, exp_end = 0, reg_start = 0, reg_end = 0;
  int prev_cyc = 0, n_strobe = 0, n_frames = 0;

  always @(negedge clk) if (rst_n) begin
    if (smp_valid) begin
      n_strobe++;
      if (!exp_active) chk(0, "R9 strobe while stopped", 1, 0);
      else begin
        logic [7:0] b [4];
        logic [15:0] el, er;
        int bpt;
        bit fe;
        for (int i = 0; i < 4; i++) b[i] = pat(exp_ptr + 24'(i));
        if (exp_b16) begin
          el = {b[0], b[1]}; er = exp_mono ? el : {b[2], b[3]};
        end else begin
          el = {b[0], 8'h00}; er = exp_mono ? el : {b[1], 8'h00};
        end
        if (exp_rate == 0) begin el = 0; er = 0; end
        chk(smp_left == el, exp_rate == 0 ? "R6 mute left" : "R4 left sample", smp_left, el);
        chk(smp_right == er, exp_rate == 0 ? "R6 mute right" : "R4 right sample", smp_right, er);
        if (have_prev)
          chk(cyc - prev_cyc == (DIVB << (3 - exp_rate)), "R5 strobe spacing",
              cyc - prev_cyc, DIVB << (3 - exp_rate));
        prev_cyc = cyc; have_prev = 1;
        bpt = (exp_b16 ? 2 : 1) * (exp_mono ? 1 : 2);
        exp_ptr = exp_ptr + 24'(bpt);
        fe = (exp_ptr >= exp_end);
        chk(frame_end == fe, "R7 frame_end", frame_end, fe);
        if (fe) begin
          n_frames++;
          chk(irq_line == cfg_irq, "R10 irq_line", irq_line, cfg_irq);
          chk(timer_evt == cfg_tmr, "R10 timer_evt", timer_evt, cfg_tmr);
          if (exp_rep) begin exp_ptr = reg_start; exp_end = reg_end; end
          else exp_active = 0;
        end
      end
    end else if (frame_end) chk(0, "R7 frame_end without strobe", 1, 0);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_raddr = a; #1 d = reg_rdata;
  endtask

  task automatic set_bufs(input logic [23:0] s, input logic [23:0] e);
    wr(4, s[23:16]); wr(5, s[15:8]); wr(6, s[7:0]);
    wr(8, e[23:16]); wr(9, e[15:8]); wr(10, e[7:0]);
    reg_start = s; reg_end = e;
  endtask

  task automatic begin_play(input bit mono, input bit b16, input logic [1:0] rate, input bit rep);
    wr(1, {mono, b16, 4'b0, rate});
    exp_mono = mono; exp_b16 = b16; exp_rate = rate; exp_rep = rep;
    exp_ptr = reg_start; exp_end = reg_end; have_prev = 0; exp_active = 1;
    wr(0, {6'b0, rep, 1'b1});
  endtask

  task automatic read_cur(output logic [23:0] v);
    logic [7:0] h, m, l;
    rd(12, h); rd(13, m); rd(14, l);
    v = (24'(h) << 16) + (24'(m) << 8) + 24'(l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [23:0] v;
    int s0, f0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    foreach (d[i]) ;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk(d == 8'h00, "R1 reset readback", d, 0);
    end
    chk(!smp_valid && !mem_req && !frame_end && !irq_line && !timer_evt,
        "R1 reset outputs", {smp_valid, mem_req, frame_end}, 0);

    // R1 register round trip
    wr(1, 8'hFF); rd(1, d); chk(d == 8'hC3, "R1 mode readback", d, 8'hC3);
    wr(2, 8'hFF); rd(2, d); chk(d == 8'h05, "R1 routing readback", d, 8'h05);
    set_bufs(24'hA1B2C3, 24'h5E6F70);
    rd(4, d); chk(d == 8'hA1, "R1 start high", d, 8'hA1);
    rd(5, d); chk(d == 8'hB2, "R1 start mid", d, 8'hB2);
    rd(6, d); chk(d == 8'hC3, "R1 start low", d, 8'hC3);
    rd(8, d); chk(d == 8'h5E, "R1 end high", d, 8'h5E);
    rd(9, d); chk(d == 8'h6F, "R1 end mid", d, 8'h6F);
    rd(10, d); chk(d == 8'h70, "R1 end low", d, 8'h70);
    rd(0, d); chk(d == 8'h00, "R1 control idle", d, 0);

    // R3/R4/R7/R10: sweep of all four formats, single frame, rate 3
    for (int fmt = 0; fmt < 4; fmt++) begin
      bit mono = fmt[0], b16 = fmt[1];
      int bpt = (b16 ? 2 : 1) * (mono ? 1 : 2);
      logic [23:0] s = 24'h12_34F0 + 24'(fmt * 3);
      cfg_irq = fmt[0]; cfg_tmr = fmt[1] ^ fmt[0];
      wr(2, {5'b0, cfg_tmr, 1'b0, cfg_irq});
      set_bufs(s, s + 24'd16);
      s0 = n_strobe; f0 = n_frames;
      begin_play(mono, b16, 2'd3, 1'b0);
      rd(0, d); chk(d == 8'h01, "R3 control running", d, 1);
      wait (!exp_active);
      repeat (40) @(negedge clk);
      chk(n_strobe - s0 == 16 / bpt, "R3 strobes per frame", n_strobe - s0, 16 / bpt);
      chk(n_frames - f0 == 1, "R7 one frame", n_frames - f0, 1);
      rd(0, d); chk(d == 8'h00, "R7 run bit cleared", d, 0);
      read_cur(v); chk(v == s + 24'd16, "R2 pointer at end", v, s + 24'd16);
    end

    // R5/R6 rate sweep, mono 8-bit, 6-byte frames
    cfg_irq = 1; cfg_tmr = 1; wr(2, 8'h05);
    for (int r = 0; r < 4; r++) begin
      set_bufs(24'h00_FFFC, 24'h01_0002);
      s0 = n_strobe;
      begin_play(1'b1, 1'b0, 2'(r), 1'b0);
      wait (!exp_active);
      repeat (20) @(negedge clk);
      chk(n_strobe - s0 == 6, "R5 strobe count", n_strobe - s0, 6);
      read_cur(v); chk(v == 24'h01_0002, "R2 pointer across byte carry", v, 24'h010002);
    end

    // R8 repeat with deferred buffer change, then R9 stop
    cfg_irq = 1; cfg_tmr = 0; wr(2, 8'h01);
    set_bufs(24'h20_0000, 24'h20_0010);
    f0 = n_frames;
    begin_play(1'b1, 1'b1, 2'd3, 1'b1);
    wait (n_strobe > 0 && smp_valid);
    @(negedge clk);
    wr(4, 8'h30); wr(5, 8'h00); wr(6, 8'h40);
    wr(8, 8'h30); wr(9, 8'h00); wr(10, 8'h48);
    reg_start = 24'h30_0040; reg_end = 24'h30_0048;
    chk(exp_end == 24'h20_0010, "R8 end unchanged mid-frame", exp_end, 24'h200010);
    wait (n_frames - f0 == 3);
    chk(exp_active == 1, "R8 still running after wraps", exp_active, 1);
    rd(0, d); chk(d == 8'h03, "R8 control repeat", d, 3);
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 0; exp_active = 0;
    s0 = n_strobe;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (mem_req) chk(0, "R9 request after stop", 1, 0);
    end
    chk(n_strobe == s0, "R9 no strobes after stop", n_strobe - s0, 0);
    rd(0, d); chk(d == 8'h00, "R9 control stopped", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule